// File: doc/BRIEF.md
# Parallel Multi-String LED Waveform Generator

This block drives several single-wire addressable-LED strings side by side, one output pin per string. Every string shares one bit timebase of 60 reference ticks (1250 ns at 48 MHz). Each bit period has three phases. At tick 0 every enabled pin goes high. At tick 12 each enabled pin drops to its own data bit. At tick 31 every pin is low, and it stays low until the period ends. One bit period therefore carries one bit to every string at once, so the frame length does not depend on how many strings are in use.

Data arrives as a stream of bit-slices over a valid/ready handshake. Bit i of a slice belongs to pin i. A start strobe captures an enable mask and a bit count. The block then runs one low lead-in period, the data periods, one low tail period, and a 2640-tick guard interval, and finally raises a done flag. If a slice is missing when it is needed, that bit goes out as zero and a sticky underrun flag is set.

Top module: `led_par_driver`

## Requirements
- R1: A bit period lasts 60 clock cycles. In every data period, all enabled pins rise together, one cycle after tick 0 of that period (the output register adds one cycle).
- R2: One cycle after tick 12, pin i takes bit i of the current slice ANDed with mask bit i. A 1 bit therefore produces a 31-cycle high pulse and a 0 bit a 12-cycle pulse.
- R3: One cycle after tick 31, every pin is low, and it stays low through the rest of the period.
- R4: Before the first data period there is one full bit period with all pins low, and after the last data period there is another. The first rise comes 61 cycles after the edge that accepts start.
- R5: After the tail period the pins stay low for a 2640-cycle guard interval, and then done rises. Counted from the start-accepting edge, done is seen 60*(N+2)+2640 cycles later, for a bit count of N.
- R6: A pin whose enable-mask bit is 0 is never driven high. The mask and the bit count are captured at the start-accepting edge.
- R7: After reset, every pin is low and done, underrun and slice_ready are all low.
- R8: A start strobe is ignored from the start-accepting edge until done rises, so frames never overlap and the running frame keeps its length.
- R9: slice_ready is high for exactly one cycle per data period, at tick 12. One slice is consumed per bit.
- R10: If slice_valid is low at tick 12, that bit is sent as 0 on every pin and underrun is set. Underrun stays set until the next accepted start clears it.
- R11: The bit count (11 bits, 0 to 1440) sets the number of data periods. A count of 0 produces no pulses and still runs the lead-in, the tail and the guard.
- R12: done stays high while idle and clears at the next accepted start. A start held high across the end of the guard starts a new frame on the edge right after done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start strobe, honoured only when idle |
| bit_count_i | input | 11 | Number of data periods in the frame |
| en_mask_i | input | 16 | Per-pin enable, captured at start |
| slice_valid_i | input | 1 | A bit-slice is offered |
| slice_data_i | input | 16 | Bit-slice, bit i for pin i |
| slice_ready_o | output | 1 | Slice consumed this cycle |
| led_o | output | 16 | String data pins |
| done_o | output | 1 | Frame and guard interval complete |
| underrun_o | output | 1 | Sticky: a slice was missing at a data point |

## Verification
Two events can fall in the same cycle: the guard interval expiring and a new start request. A start held high across the final guard cycle can be read by two functions at that edge. One is the completion logic that raises done. The other is the sequencer, which could wrongly accept the start while still busy. The bench raises start two cycles before done is due and keeps it high. It then checks that done arrives at exactly the expected cycle, that it is high for one cycle only, and that the next frame, timed from the following edge, has the full length.

// File: rtl/led_par_pkg.sv
package led_par_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_TAIL,
        ST_GUARD
    } frame_st_e;

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
    parameter int unsigned TICKS_PER_BIT = 60,
    parameter int unsigned DATA_TICK     = 12,
    parameter int unsigned LOW_TICK      = 31,
    localparam int unsigned TICK_W       = $clog2(TICKS_PER_BIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic period_end,
    output logic at_rise,
    output logic at_data,
    output logic at_low
);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.tick = '0;
        end else if (tmr_q.tick == TICK_W'(TICKS_PER_BIT - 1)) begin
            tmr_d.tick = '0;
        end else begin
            tmr_d.tick = tmr_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign period_end = run && (tmr_q.tick == TICK_W'(TICKS_PER_BIT - 1));
    assign at_rise    = run && (tmr_q.tick == '0);
    assign at_data    = run && (tmr_q.tick == TICK_W'(DATA_TICK));
    assign at_low     = run && (tmr_q.tick == TICK_W'(LOW_TICK));

    // R1: the phase counter never leaves its period
    p_tick_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.tick < TICK_W'(TICKS_PER_BIT));

    // R5: the timer is parked at zero whenever the sequencer stops it
    p_timer_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> tmr_q.tick == '0);

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
    import led_par_pkg::*;
#(
    parameter int unsigned CNT_W       = 11,
    parameter int unsigned GUARD_TICKS = 2640,
    localparam int unsigned GRD_W      = $clog2(GUARD_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             period_end,
    output logic             accept,
    output logic             run,
    output logic             in_bits,
    output logic             done
);

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  bits_left;
        logic [GRD_W-1:0]  guard;
        logic              done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st        = ST_LEAD;
                    seq_d.bits_left = bit_count;
                    seq_d.done      = 1'b0;
                end
            end
            ST_LEAD: begin
                if (period_end) seq_d.st = (seq_q.bits_left == '0) ? ST_TAIL : ST_BITS;
            end
            ST_BITS: begin
                if (period_end) begin
                    seq_d.bits_left = seq_q.bits_left - 1'b1;
                    if (seq_q.bits_left == CNT_W'(1)) seq_d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (period_end) begin
                    seq_d.st    = ST_GUARD;
                    seq_d.guard = '0;
                end
            end
            ST_GUARD: begin
                if (seq_q.guard == GRD_W'(GUARD_TICKS - 1)) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.guard = seq_q.guard + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, bits_left: '0, guard: '0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign accept  = (seq_q.st == ST_IDLE) && start;
    assign run     = (seq_q.st == ST_LEAD) || (seq_q.st == ST_BITS) || (seq_q.st == ST_TAIL);
    assign in_bits = (seq_q.st == ST_BITS);
    assign done    = seq_q.done;

    // R8: a frame can only begin from idle, never while one is in flight
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |=> (seq_q.st != ST_LEAD) || ($past(seq_q.st) == ST_LEAD));

    // R5: done rises only as the guard interval ends
    p_done_after_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.done) |-> $past(seq_q.st) == ST_GUARD);

    // R12: done is cleared only by an accepted start
    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.done) |-> $past(seq_q.st) == ST_IDLE && $past(start));

endmodule

// File: rtl/led_pin_shaper.sv
module led_pin_shaper #(
    parameter int unsigned N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [N_PINS-1:0] mask_in,
    input  logic              in_bits,
    input  logic              at_rise,
    input  logic              at_data,
    input  logic              at_low,
    input  logic              slice_valid,
    input  logic [N_PINS-1:0] slice_data,
    output logic              slice_ready,
    output logic [N_PINS-1:0] pins,
    output logic              underrun
);

    typedef struct packed {
        logic [N_PINS-1:0] mask;
        logic [N_PINS-1:0] pins;
        logic              underrun;
    } shp_s;

    shp_s shp_d, shp_q;
    logic [N_PINS-1:0] pin_nxt;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign pin_nxt[g] = !in_bits ? 1'b0
                          : at_rise  ? shp_q.mask[g]
                          : at_data  ? (slice_valid & slice_data[g] & shp_q.mask[g])
                          : at_low   ? 1'b0
                          :            shp_q.pins[g];
    end

    always_comb begin
        shp_d      = shp_q;
        shp_d.pins = pin_nxt;
        if (capture) begin
            shp_d.mask     = mask_in;
            shp_d.underrun = 1'b0;
        end else if (in_bits && at_data && !slice_valid) begin
            shp_d.underrun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shp_q <= '0;
        else        shp_q <= shp_d;
    end

    assign slice_ready = in_bits && at_data;
    assign pins        = shp_q.pins;
    assign underrun    = shp_q.underrun;

    // R6: a disabled pin is never high
    p_masked_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shp_q.pins & ~shp_q.mask) == '0);

    // R4: outside data periods the pins settle low
    p_quiet_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_bits |=> shp_q.pins == '0);

    // R10: underrun survives until a new frame is accepted
    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shp_q.underrun && !capture) |=> shp_q.underrun);

endmodule

// File: rtl/led_par_driver.sv
module led_par_driver #(
    parameter int unsigned N_STRINGS     = 16,
    parameter int unsigned TICKS_PER_BIT = 60,
    parameter int unsigned DATA_TICK     = 12,
    parameter int unsigned LOW_TICK      = 31,
    parameter int unsigned GUARD_TICKS   = 2640,
    parameter int unsigned MAX_BITS      = 1440,
    localparam int unsigned CNT_W        = $clog2(MAX_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     bit_count_i,
    input  logic [N_STRINGS-1:0] en_mask_i,
    input  logic                 slice_valid_i,
    input  logic [N_STRINGS-1:0] slice_data_i,
    output logic                 slice_ready_o,
    output logic [N_STRINGS-1:0] led_o,
    output logic                 done_o,
    output logic                 underrun_o
);

    logic period_end, at_rise, at_data, at_low;
    logic accept, run, in_bits;

    led_phase_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .DATA_TICK    (DATA_TICK),
        .LOW_TICK     (LOW_TICK)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .period_end(period_end),
        .at_rise   (at_rise),
        .at_data   (at_data),
        .at_low    (at_low)
    );

    led_frame_seq #(
        .CNT_W      (CNT_W),
        .GUARD_TICKS(GUARD_TICKS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .bit_count (bit_count_i),
        .period_end(period_end),
        .accept    (accept),
        .run       (run),
        .in_bits   (in_bits),
        .done      (done_o)
    );

    led_pin_shaper #(
        .N_PINS(N_STRINGS)
    ) shaper_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (accept),
        .mask_in    (en_mask_i),
        .in_bits    (in_bits),
        .at_rise    (at_rise),
        .at_data    (at_data),
        .at_low     (at_low),
        .slice_valid(slice_valid_i),
        .slice_data (slice_data_i),
        .slice_ready(slice_ready_o),
        .pins       (led_o),
        .underrun   (underrun_o)
    );

    // R9: a slice is taken only at the data point of a data period
    p_ready_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slice_ready_o |-> in_bits && !$past(slice_ready_o));

endmodule

// File: tb/led_par_driver_tb_top.sv
module led_par_driver_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] bit_count_i = '0;
    logic [15:0] en_mask_i = '0;
    logic        slice_valid_i = 1'b0;
    logic [15:0] slice_data_i = '0;
    logic        slice_ready_o;
    logic [15:0] led_o;
    logic        done_o;
    logic        underrun_o;

    always #4 clk = ~clk;

    led_par_driver dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .bit_count_i  (bit_count_i),
        .en_mask_i    (en_mask_i),
        .slice_valid_i(slice_valid_i),
        .slice_data_i (slice_data_i),
        .slice_ready_o(slice_ready_o),
        .led_o        (led_o),
        .done_o       (done_o),
        .underrun_o   (underrun_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int rdy_cnt = 0;
    int first_rise = -1;
    logic [15:0] expq[$];
    logic [15:0] sl[16];
    logic [15:0] cur_mask = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected slice per observed rise and checks the phases
    initial begin
        logic prev;
        logic [15:0] e;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (|led_o && !prev) begin
                rise_cnt++;
                if (first_rise < 0) first_rise = cyc;
                e = (expq.size() > 0) ? expq.pop_front() : 16'hDEAD;
                chk(led_o == cur_mask, "R1 all enabled high at rise", led_o, cur_mask);
                repeat (11) @(negedge clk);
                chk(led_o == cur_mask, "R2 high before data point", led_o, cur_mask);
                @(negedge clk);
                chk(led_o == e, "R2 data bits after tick 12", led_o, e);
                repeat (18) @(negedge clk);
                chk(led_o == e, "R2 data bits held to tick 31", led_o, e);
                @(negedge clk);
                chk(led_o == 16'h0, "R3 all low after tick 31", led_o, 16'h0);
            end
            prev = |led_o;
        end
    end

    always @(negedge clk) if (slice_ready_o) rdy_cnt++;

    task automatic run_frame(input logic [15:0] mask, input int n, input logic [15:0] skip, input int poke_at);
        int acc;
        int dcyc;
        rise_cnt = 0;
        rdy_cnt = 0;
        first_rise = -1;
        expq.delete();
        @(negedge clk);
        en_mask_i = mask;
        bit_count_i = 11'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        acc = cyc;
        cur_mask = mask;
        chk(done_o == 1'b0, "R12 done cleared by start", done_o, 0);
        chk(underrun_o == 1'b0, "R10 underrun cleared by start", underrun_o, 0);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    slice_valid_i = !skip[i];
                    slice_data_i = sl[i];
                    expq.push_back(skip[i] ? 16'h0 : (sl[i] & mask));
                    while (!slice_ready_o) @(negedge clk);
                    @(negedge clk);
                    slice_valid_i = 1'b0;
                end
            end
            begin
                if (poke_at > 0) begin
                    while (cyc < acc + poke_at) @(negedge clk);
                    bit_count_i = 11'd5;
                    en_mask_i = 16'h0001;
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
            begin
                while (!done_o) @(negedge clk);
                dcyc = cyc;
            end
        join
        chk(dcyc - acc == 60 * (n + 2) + 2640, "R5 start-to-done cycles", dcyc - acc, 60 * (n + 2) + 2640);
        chk(rise_cnt == ((mask != 0) ? n : 0), "R11 one pulse per counted bit", rise_cnt, (mask != 0) ? n : 0);
        chk(rdy_cnt == n, "R9 one ready cycle per bit", rdy_cnt, n);
        if (n > 0 && mask != 0)
            chk(first_rise - acc == 61, "R4 lead-in before first rise", first_rise - acc, 61);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(led_o == 16'h0, "R7 pins low in reset", led_o, 0);
        chk(done_o == 1'b0, "R7 done low in reset", done_o, 0);
        chk(underrun_o == 1'b0, "R7 underrun low in reset", underrun_o, 0);
        chk(slice_ready_o == 1'b0, "R7 ready low in reset", slice_ready_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(led_o == 16'h0 && done_o == 1'b0, "R7 idle after reset", {led_o, 15'b0, done_o}, 0);

        // R1 R2 R3: mixed patterns on every pin
        sl[0] = 16'hA5A5; sl[1] = 16'hFFFF; sl[2] = 16'h0000; sl[3] = 16'h1234;
        run_frame(16'hFFFF, 4, 16'h0, 0);
        chk(underrun_o == 1'b0, "R10 no underrun with steady data", underrun_o, 0);
        repeat (50) @(negedge clk);
        chk(done_o == 1'b1, "R12 done held while idle", done_o, 1);

        // R6: only enabled pins move
        sl[0] = 16'hFFFF; sl[1] = 16'h0F0F;
        run_frame(16'h00F0, 2, 16'h0, 0);

        // R10: missing slice in the middle slot
        sl[0] = 16'h8001; sl[1] = 16'hFFFF; sl[2] = 16'h7FFE;
        run_frame(16'hFFFF, 3, 16'h0002, 0);
        chk(underrun_o == 1'b1, "R10 underrun set", underrun_o, 1);
        repeat (100) @(negedge clk);
        chk(underrun_o == 1'b1, "R10 underrun sticky", underrun_o, 1);

        // R11: zero-length frame (start also clears underrun, checked in task)
        run_frame(16'hFFFF, 0, 16'h0, 0);

        // R8: start while busy must not restart or alter the frame
        sl[0] = 16'h3C3C; sl[1] = 16'hC3C3;
        run_frame(16'hFFFF, 2, 16'h0, 300);
        repeat (20) @(negedge clk);
        chk(led_o == 16'h0 && done_o == 1'b1, "R8 no second frame after ignored start", {led_o, 15'b0, done_o}, 1);

        // R12: start held across the guard end
        begin
            int acc;
            int acc2;
            @(negedge clk);
            bit_count_i = 11'd0;
            en_mask_i = 16'hFFFF;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            acc = cyc;
            while (cyc < acc + 2760 - 2) @(negedge clk);
            start_i = 1'b1;
            while (!done_o) @(negedge clk);
            chk(cyc - acc == 2760, "R5 done on time with start pending", cyc - acc, 2760);
            @(negedge clk);
            chk(done_o == 1'b0, "R12 done high one cycle then restart", done_o, 0);
            start_i = 1'b0;
            acc2 = cyc;
            while (!done_o) @(negedge clk);
            chk(cyc - acc2 == 2760, "R12 restarted frame full length", cyc - acc2, 2760);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule